// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Match Alarm

This block is a memory-mapped real-time clock. It keeps a seconds count that advances once per second. The one-second tick comes from dividing the block clock by a parameterised ratio. Software reaches the block through a simple 32-bit register bus with a byte address, a write strobe with write data, and a read strobe. Read data is registered and appears one cycle after the read strobe.

Software sets the time by writing a load register. The value is held pending and is copied into the counter on the next tick, not at once. A match register sets the alarm second. When a tick finds the counter equal to the match value, a raw alarm flag is set. That flag reaches the interrupt pin only when the interrupt-enable control bit is set and the mask bit is clear. Reading the acknowledge register clears the flag. A wrap control sends the counter back to zero on a matching tick.

Top module: `rtc_sec_counter`

## Requirements
- R1: After reset the counter, the match value, the control bits and both status registers read zero, and `alarm_irq` is low.
- R2: Register word offsets are 0x00 counter (read-only), 0x04 match, 0x08 load, 0x0C control, 0x10 gated status, 0x14 raw status, 0x18 acknowledge, 0x1C version. Match and load read back the last written value. Control reads back bits [3:0] only. The version register returns the `VERSION` parameter.
- R3: Control bit 2 (run) enables the counter. While run is set, the counter rises by one every `TICK_DIV` clock cycles. Clearing run freezes the counter and restarts the divider, so an interval shorter than `TICK_DIV` cycles never produces a tick.
- R4: A write to the load register does not change the counter. On the next tick the counter takes the loaded value, and this takes priority over both the increment and the wrap-to-zero.
- R5: On any tick where the counter equals the match value, raw status bit 0 is set, whatever the enable and mask bits are.
- R6: `alarm_irq` and gated status bit 0 both equal the raw flag AND control bit 0 (interrupt enable) AND NOT control bit 1 (mask).
- R7: A read of the acknowledge register returns zero and clears the raw flag, so `alarm_irq` falls.
- R8: Control bit 3 (wrap) makes a matching tick set the counter to zero instead of incrementing it. Without it, the counter goes past the match value and rolls over from all-ones to zero.
- R9: Writes to the counter, status, acknowledge and version offsets have no effect. Reads of misaligned addresses or of addresses at 0x20 and above return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; the acknowledge read has a side effect |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd`, zero otherwise |
| alarm_irq | output | 1 | Alarm interrupt, level, gated by enable and mask |

## Verification
The case hardest to reach from the ports is a tick that happens at a chosen counter value, while a load is pending or a match is due. The free-running divider makes the exact tick cycle hard to see. The bench therefore keeps run clear between steps and opens it for exactly `TICK_DIV` times k cycles. Each step then makes a known number of ticks, and the frozen state is read back at leisure. A sweep over match distances, a load racing a matching tick, and an all-ones rollover are all driven this way.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;
   typedef enum logic [2:0] {
      IDX_NOW   = 3'd0,
      IDX_MATCH = 3'd1,
      IDX_LOAD  = 3'd2,
      IDX_CTRL  = 3'd3,
      IDX_GSTAT = 3'd4,
      IDX_RSTAT = 3'd5,
      IDX_ACK   = 3'd6,
      IDX_VER   = 3'd7
   } reg_idx_e;

   // control layout, bit 3 down to bit 0
   typedef struct packed {
      logic wrap;
      logic run;
      logic mask;
      logic ie;
   } ctrl_t;

   localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/rtc_sec_tick.sv
module rtc_sec_tick #(
   parameter int unsigned TICK_DIV = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic tick_o
);
   generate
      if (TICK_DIV < 1) begin : g_bad_div
         $error("rtc_sec_tick: TICK_DIV must be at least 1");
      end

      if (TICK_DIV == 1) begin : g_pass
         assign tick_o = run_i;
      end else begin : g_div
         localparam int unsigned DW = $clog2(TICK_DIV);
         localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);
         logic [DW-1:0] div_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              div_q <= '0;
            else if (!run_i)         div_q <= '0;
            else if (div_q == LAST)  div_q <= '0;
            else                     div_q <= div_q + 1'b1;
         end

         assign tick_o = run_i && (div_q == LAST);

         // R3
         tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tick_o |=> !tick_o);
      end
   endgenerate
endmodule

// File: rtl/rtc_sec_core.sv
module rtc_sec_core #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             wrap_en_i,
   input  logic             load_wr_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic [CNT_W-1:0] match_i,
   input  logic             ack_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] load_o,
   output logic             raw_o
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] load_q;
   logic             pend_q;
   logic             raw_q;
   logic             hit;

   assign hit = tick_i && (cnt_q == match_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         load_q <= '0;
         pend_q <= 1'b0;
      end else begin
         if (tick_i) begin
            if (pend_q)                 cnt_q <= load_q;
            else if (hit && wrap_en_i)  cnt_q <= '0;
            else                        cnt_q <= cnt_q + 1'b1;
            pend_q <= 1'b0;
         end
         // a new load on a tick edge stays pending for the next tick
         if (load_wr_i) begin
            load_q <= load_val_i;
            pend_q <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q <= 1'b0;
      end else begin
         if (ack_i) raw_q <= 1'b0;
         if (hit)   raw_q <= 1'b1;
      end
   end

   assign cnt_o  = cnt_q;
   assign load_o = load_q;
   assign raw_o  = raw_q;

   // R3
   hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(cnt_q));

   // R4
   load_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && pend_q) |=> (cnt_q == $past(load_q)));

   // R5
   raw_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw_q) |-> $past(tick_i));

   // R7
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !tick_i) |=> !raw_q);

   // R8
   wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && wrap_en_i && !pend_q && cnt_q == match_i) |=> (cnt_q == '0));
endmodule

// File: rtl/rtc_sec_regs.sv
module rtc_sec_regs
   import rtc_sec_pkg::*;
#(
   parameter int unsigned CNT_W   = 32,
   parameter int unsigned ADDR_W  = 8,
   parameter logic [31:0] VERSION = 32'h0000_0104
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_rd,
   output logic [31:0]       bus_rdata,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic [CNT_W-1:0]  load_i,
   input  logic              raw_i,
   input  logic              irq_i,
   output ctrl_t             ctrl_o,
   output logic [CNT_W-1:0]  match_o,
   output logic              load_wr_o,
   output logic              ack_o
);
   logic        in_map;
   reg_idx_e    idx;
   ctrl_t       ctrl_q;
   logic [CNT_W-1:0] match_q;
   logic [31:0] rd_mux;
   logic [31:0] rdata_q;

   assign in_map = (bus_addr[1:0] == 2'b00) && ((bus_addr >> 5) == '0);
   assign idx    = reg_idx_e'(bus_addr[4:2]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         match_q <= '0;
      end else if (bus_wr && in_map) begin
         case (idx)
            IDX_MATCH: match_q <= bus_wdata[CNT_W-1:0];
            IDX_CTRL:  ctrl_q  <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            default:   ;
         endcase
      end
   end

   assign load_wr_o = bus_wr && in_map && (idx == IDX_LOAD);
   assign ack_o     = bus_rd && in_map && (idx == IDX_ACK);

   always_comb begin
      rd_mux = '0;
      if (in_map) begin
         case (idx)
            IDX_NOW:   rd_mux = 32'(cnt_i);
            IDX_MATCH: rd_mux = 32'(match_q);
            IDX_LOAD:  rd_mux = 32'(load_i);
            IDX_CTRL:  rd_mux = {{(32-CTRL_W){1'b0}}, ctrl_q};
            IDX_GSTAT: rd_mux = {31'd0, irq_i};
            IDX_RSTAT: rd_mux = {31'd0, raw_i};
            IDX_VER:   rd_mux = VERSION;
            default:   rd_mux = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (bus_rd) rdata_q <= rd_mux;
      else             rdata_q <= '0;
   end

   assign bus_rdata = rdata_q;
   assign ctrl_o    = ctrl_q;
   assign match_o   = match_q;

   // R9
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !in_map) |=> (bus_rdata == '0));

   // R2
   version_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && in_map && idx == IDX_VER) |=> (bus_rdata == VERSION));

   // R9
   ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && in_map && idx != IDX_MATCH && idx != IDX_CTRL) |=>
         ($stable(match_q) && $stable(ctrl_q)));
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter
   import rtc_sec_pkg::*;
#(
   parameter int unsigned CNT_W    = 32,
   parameter int unsigned TICK_DIV = 32768,
   parameter int unsigned ADDR_W   = 8,
   parameter logic [31:0] VERSION  = 32'h0000_0104
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_rd,
   output logic [31:0]       bus_rdata,
   output logic              alarm_irq
);
   generate
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
         $error("rtc_sec_counter: CNT_W must be 1..32");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("rtc_sec_counter: ADDR_W must be at least 5");
      end
   endgenerate

   ctrl_t            ctrl;
   logic             tick;
   logic             raw;
   logic             load_wr;
   logic             ack;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] load_val;
   logic [CNT_W-1:0] match_val;

   rtc_sec_tick #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (ctrl.run),
      .tick_o (tick)
   );

   rtc_sec_core #(.CNT_W(CNT_W)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick),
      .wrap_en_i  (ctrl.wrap),
      .load_wr_i  (load_wr),
      .load_val_i (bus_wdata[CNT_W-1:0]),
      .match_i    (match_val),
      .ack_i      (ack),
      .cnt_o      (cnt),
      .load_o     (load_val),
      .raw_o      (raw)
   );

   rtc_sec_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .VERSION(VERSION)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata),
      .cnt_i     (cnt),
      .load_i    (load_val),
      .raw_i     (raw),
      .irq_i     (alarm_irq),
      .ctrl_o    (ctrl),
      .match_o   (match_val),
      .load_wr_o (load_wr),
      .ack_o     (ack)
   );

   assign alarm_irq = raw & ctrl.ie & ~ctrl.mask;

   // R3
   frozen_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.run |=> $stable(cnt));
endmodule

// File: tb/tb_rtc_sec_counter.sv
`timescale 1ns/1ps
module tb_rtc_sec_counter;
   localparam int unsigned DIV = 4;
   localparam logic [31:0] VER = 32'h0000_0104;
   localparam logic [7:0] A_NOW = 8'h00, A_MATCH = 8'h04, A_LOAD = 8'h08, A_CTRL = 8'h0C,
                          A_GST = 8'h10, A_RST = 8'h14, A_ACK = 8'h18, A_VER = 8'h1C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic        alarm_irq;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;
   logic [3:0]  ctl = 4'h0;
   logic [31:0] v;

   always #10 clk = ~clk;

   rtc_sec_counter #(.CNT_W(32), .TICK_DIV(DIV), .ADDR_W(8), .VERSION(VER)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .alarm_irq(alarm_irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // opens run for exactly k ticks, then freezes the counter again
   task automatic run_ticks(input int k);
      if (k > 0) begin
         wr(A_CTRL, {28'd0, ctl | 4'h4});
         idle(k * DIV - 1);
         wr(A_CTRL, {28'd0, ctl});
      end
   endtask

   task automatic set_ctl(input logic [3:0] c);
      ctl = c;
      wr(A_CTRL, {28'd0, c});
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      rd(A_NOW, v);   check("R1 counter", v, 32'd0);
      rd(A_MATCH, v); check("R1 match", v, 32'd0);
      rd(A_CTRL, v);  check("R1 control", v, 32'd0);
      rd(A_RST, v);   check("R1 raw status", v, 32'd0);
      rd(A_GST, v);   check("R1 gated status", v, 32'd0);
      check("R1 irq", {31'd0, alarm_irq}, 32'd0);

      // R2 map and readback
      rd(A_VER, v);   check("R2 version", v, VER);
      wr(A_MATCH, 32'h0000_1234);
      rd(A_MATCH, v); check("R2 match readback", v, 32'h0000_1234);
      wr(A_CTRL, 32'hFFFF_FFFA);
      rd(A_CTRL, v);  check("R2 control 4 bits", v, 32'h0000_000A);
      set_ctl(4'h0);

      // R4 load is pending until a tick
      wr(A_LOAD, 32'd100);
      rd(A_LOAD, v);  check("R2 load readback", v, 32'd100);
      rd(A_NOW, v);   check("R4 no immediate load", v, 32'd0);
      idle(20);
      rd(A_NOW, v);   check("R3 frozen while stopped", v, 32'd0);
      // R3 two short run windows: divider restarts, so no tick
      wr(A_CTRL, 32'h4); idle(DIV - 2); wr(A_CTRL, 32'h0);
      wr(A_CTRL, 32'h4); idle(DIV - 2); wr(A_CTRL, 32'h0);
      rd(A_NOW, v);   check("R3 divider restart", v, 32'd0);
      run_ticks(1);
      rd(A_NOW, v);   check("R4 load on tick", v, 32'd100);
      run_ticks(3);
      rd(A_NOW, v);   check("R3 increments", v, 32'd103);

      // R4 load beats wrap on a matching tick; R5 raw still set
      wr(A_MATCH, 32'd103);
      wr(A_LOAD, 32'd50);
      set_ctl(4'h8);
      run_ticks(1);
      rd(A_NOW, v);   check("R4 load priority", v, 32'd50);
      rd(A_RST, v);   check("R5 raw on match", v, 32'd1);
      rd(A_ACK, v);   check("R7 ack reads zero", v, 32'd0);
      rd(A_RST, v);   check("R7 raw cleared", v, 32'd0);
      set_ctl(4'h0);

      // R5 sweep over match distance
      for (int d = 0; d < 5; d++) begin
         logic [31:0] base;
         base = 32'd1000 * (d + 1) + 32'd10;
         rd(A_ACK, v);
         wr(A_LOAD, base);
         wr(A_MATCH, base + d);
         run_ticks(1);
         run_ticks(d);
         rd(A_NOW, v);  check("R5 sweep counter", v, base + d);
         rd(A_RST, v);  check("R5 sweep no early raw", v, 32'd0);
         run_ticks(1);
         rd(A_RST, v);  check("R5 sweep raw set", v, 32'd1);
         rd(A_NOW, v);  check("R8 passes match without wrap", v, base + d + 1);
      end

      // R6 gating sweep with raw set
      for (int c = 0; c < 4; c++) begin
         logic exp_irq;
         exp_irq = (c[0] == 1'b1) && (c[1] == 1'b0);
         set_ctl({2'b00, c[1], c[0]});
         check("R6 irq pin", {31'd0, alarm_irq}, {31'd0, exp_irq});
         rd(A_GST, v);  check("R6 gated status", v, {31'd0, exp_irq});
         rd(A_RST, v);  check("R6 raw status", v, 32'd1);
      end
      set_ctl(4'h1);
      check("R6 irq enabled", {31'd0, alarm_irq}, 32'd1);

      // R9 writes to read-only offsets ignored
      wr(A_RST, 32'h0);
      wr(A_ACK, 32'h0);
      wr(A_GST, 32'h0);
      check("R9 irq kept after ro writes", {31'd0, alarm_irq}, 32'd1);
      rd(A_ACK, v);
      check("R7 irq falls", {31'd0, alarm_irq}, 32'd0);
      rd(A_NOW, v);
      wr(A_NOW, 32'h55);
      begin
         logic [31:0] w;
         rd(A_NOW, w);  check("R9 counter write ignored", w, v);
      end
      wr(A_VER, 32'hDEAD_BEEF);
      rd(A_VER, v);  check("R9 version write ignored", v, VER);
      rd(8'h20, v);  check("R9 unmapped 0x20", v, 32'd0);
      rd(8'h02, v);  check("R9 misaligned", v, 32'd0);
      rd(8'hFC, v);  check("R9 unmapped 0xFC", v, 32'd0);

      // R8 wrap to zero
      set_ctl(4'h8);
      wr(A_LOAD, 32'd0);
      wr(A_MATCH, 32'd2);
      run_ticks(4);
      rd(A_NOW, v);  check("R8 wrap to zero", v, 32'd0);
      rd(A_RST, v);  check("R8 raw at wrap", v, 32'd1);
      run_ticks(1);
      rd(A_NOW, v);  check("R8 counts after wrap", v, 32'd1);
      rd(A_ACK, v);

      // R8 natural rollover
      set_ctl(4'h0);
      wr(A_MATCH, 32'd5);
      wr(A_LOAD, 32'hFFFF_FFFF);
      run_ticks(1);
      rd(A_NOW, v);  check("R8 all-ones loaded", v, 32'hFFFF_FFFF);
      run_ticks(1);
      rd(A_NOW, v);  check("R8 rollover", v, 32'd0);
      rd(A_RST, v);  check("R5 no spurious raw", v, 32'd0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule